// File: doc/BRIEF.md
# I2C Master Command and Data Queue Front End

This block sits between a register bus and the serial engine of an I2C master. Software writes to a single data/command location. Each write either queues a byte to transmit or queues a request to receive one byte. Reading the same location pops the oldest received byte. A downstream bit engine takes commands through a valid/ready handshake and delivers received bytes through a valid strobe. The serial timing and the interrupt bank are not part of this block.

The block keeps a command FIFO and a receive FIFO. It exposes their fill levels and programmable thresholds, and it turns them into level events for the interrupt logic: command queue low, receive queue above threshold, and the overflow and underflow strobes. An abort from the bit engine flushes both FIFOs. Clearing the enable bit also flushes them and holds them empty. The slave address and the ten-bit addressing flag can only be changed while the controller is disabled. DEPTH must be a power of two.

Register map (reg_addr): 0 data/command, 1 control (bit0 enable, bit1 ten-bit mode), 2 target address (bits 9:0), 3 command threshold, 4 receive threshold, 5 command level (read only), 6 receive level (read only).

Top module: `i2cm_cmd_front`

## Requirements
- R1: A write to address 0 with bit 8 clear queues bits 7:0 as a transmit command (cmd_data[8]=0). With bit 8 set, it queues a read request (cmd_data[8]=1, cmd_data[7:0]=0). Commands appear on cmd_data in the order they were written, and cmd_valid is high while the command FIFO is non-empty.
- R2: A read of address 5 returns the command FIFO level and a read of address 6 returns the receive FIFO level. Both are sampled before the edge of the read.
- R3: ev_tx_empty is high when the command level is at or below the command threshold. ev_rx_full is high when the receive level is above the receive threshold. Both are registered one cycle after the level.
- R4: A data write while the command FIFO holds DEPTH entries is dropped, and ev_tx_over pulses for one cycle.
- R5: A read of address 0 while the receive FIFO is empty returns 0, and ev_rx_under pulses for one cycle.
- R6: A byte on rx_valid while the receive FIFO holds DEPTH entries is dropped, and ev_rx_over pulses for one cycle.
- R7: xfer_abort empties both FIFOs at that edge. Overflow and underflow strobes and read data are still produced from the levels before the abort.
- R8: Control bit 0 enables the controller. While it is clear, both levels are zero from the next edge, data writes are ignored and cmd_valid is low.
- R9: The target address (address 2) and the ten-bit flag (control bit 1) change only on writes made while the controller is disabled.
- R10: Received bytes are returned in arrival order on reg_rdata one cycle after the read of address 0.
- R11: A push and a pop on the same FIFO in the same cycle both take effect. Whether the push is accepted depends on the level before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| cmd_valid | output | 1 | Command available for the bit engine |
| cmd_ready | input | 1 | Bit engine takes the command |
| cmd_data | output | 9 | Bit 8 read request, bits 7:0 byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| xfer_abort | input | 1 | Transfer abort, flushes both FIFOs |
| ctl_enabled | output | 1 | Enable bit |
| tgt_addr | output | 10 | Slave address |
| ten_bit_mode | output | 1 | Ten-bit addressing flag |
| ev_tx_empty | output | 1 | Command level at or below threshold |
| ev_rx_full | output | 1 | Receive level above threshold |
| ev_tx_over | output | 1 | Command overflow pulse |
| ev_rx_over | output | 1 | Receive overflow pulse |
| ev_rx_under | output | 1 | Receive underflow pulse |

## Verification
Both FIFOs can be pushed and popped in the same cycle. The command FIFO sees a software write alongside an engine handshake. The receive FIFO sees an engine byte alongside a software read, and an abort can land on top of either. Random phases drive all of these inputs independently every cycle, one phase biased to keep both FIFOs full and one to keep them drained. A bench queue model then predicts the next head command, the read data, every level and every event strobe, and checks where the cycle had a simultaneous push and pop are tagged as such.

// File: rtl/i2cm_front_pkg.sv
package i2cm_front_pkg;
  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_CTRL   = 3'd1,
    RA_TARGET = 3'd2,
    RA_TXTHR  = 3'd3,
    RA_RXTHR  = 3'd4,
    RA_TXLVL  = 3'd5,
    RA_RXLVL  = 3'd6
  } reg_addr_e;

  localparam int READ_FLAG_BIT = 8;
  localparam int CMD_W = 9;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_sfifo.sv
module i2cm_sfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             do_push, do_pop;

  assign do_push = push && (level != LW'(DEPTH));
  assign do_pop  = pop && (level != '0);

  // storage has no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  assign dout = mem[rptr];

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0));
  assert_empty_pop_safe_R11: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && !push) |=> (level == '0));
endmodule

// File: rtl/i2cm_fifo_events.sv
module i2cm_fifo_events #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] rx_thr,
  input  logic          tx_over_s,
  input  logic          rx_over_s,
  input  logic          rx_under_s,
  output logic          ev_tx_empty,
  output logic          ev_rx_full,
  output logic          ev_tx_over,
  output logic          ev_rx_over,
  output logic          ev_rx_under
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_tx_empty <= 1'b0;
      ev_rx_full  <= 1'b0;
      ev_tx_over  <= 1'b0;
      ev_rx_over  <= 1'b0;
      ev_rx_under <= 1'b0;
    end else begin
      ev_tx_empty <= (tx_lvl <= tx_thr);
      ev_rx_full  <= (rx_lvl > rx_thr);
      ev_tx_over  <= tx_over_s;
      ev_rx_over  <= rx_over_s;
      ev_rx_under <= rx_under_s;
    end
  end

  assert_rx_full_level_R3: assert property (@(posedge clk) disable iff (rst)
    ev_rx_full |-> ($past(rx_lvl) != '0));
endmodule

// File: rtl/i2cm_cmd_front.sv
module i2cm_cmd_front
  import i2cm_front_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int REG_W = 16,
  parameter int TGT_W = 10,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_data,
  input  logic             rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic             xfer_abort,
  output logic             ctl_enabled,
  output logic [TGT_W-1:0] tgt_addr,
  output logic             ten_bit_mode,
  output logic             ev_tx_empty,
  output logic             ev_rx_full,
  output logic             ev_tx_over,
  output logic             ev_rx_over,
  output logic             ev_rx_under
);
  logic              en_q, ten_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [LW-1:0]     txthr_q, rxthr_q;
  logic [LW-1:0]     tx_lvl, rx_lvl;
  logic [CMD_W-1:0]  tx_din, tx_dout;
  logic [BYTE_W-1:0] rx_dout;
  logic              wr_data, rd_data, flush, tx_pop;

  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign rd_data = reg_rd && (reg_addr == RA_DATA);
  assign flush   = xfer_abort || !en_q;
  assign tx_din  = reg_wdata[READ_FLAG_BIT] ? {1'b1, {BYTE_W{1'b0}}}
                                            : {1'b0, reg_wdata[BYTE_W-1:0]};
  assign cmd_valid = en_q && (tx_lvl != '0);
  assign tx_pop    = cmd_valid && cmd_ready;
  assign cmd_data  = tx_dout;

  i2cm_sfifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush), .push(wr_data && en_q),
    .din(tx_din), .pop(tx_pop), .dout(tx_dout), .level(tx_lvl));

  i2cm_sfifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush), .push(rx_valid && en_q),
    .din(rx_byte), .pop(rd_data), .dout(rx_dout), .level(rx_lvl));

  i2cm_fifo_events #(.LW(LW)) u_evt (
    .clk(clk), .rst(rst), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .tx_thr(txthr_q), .rx_thr(rxthr_q),
    .tx_over_s(wr_data && en_q && (tx_lvl == LW'(DEPTH))),
    .rx_over_s(rx_valid && en_q && (rx_lvl == LW'(DEPTH))),
    .rx_under_s(rd_data && (rx_lvl == '0)),
    .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full),
    .ev_tx_over(ev_tx_over), .ev_rx_over(ev_rx_over),
    .ev_rx_under(ev_rx_under));

  // control registers; address and mode are locked while enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      ten_q   <= 1'b0;
      tgt_q   <= '0;
      txthr_q <= '0;
      rxthr_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          en_q <= reg_wdata[0];
          if (!en_q) ten_q <= reg_wdata[1];
        end
        RA_TARGET: if (!en_q) tgt_q <= reg_wdata[TGT_W-1:0];
        RA_TXTHR:  txthr_q <= reg_wdata[LW-1:0];
        RA_RXTHR:  rxthr_q <= reg_wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_DATA:   reg_rdata <= (rx_lvl != '0) ? REG_W'(rx_dout) : '0;
        RA_CTRL:   reg_rdata <= REG_W'({ten_q, en_q});
        RA_TARGET: reg_rdata <= REG_W'(tgt_q);
        RA_TXTHR:  reg_rdata <= REG_W'(txthr_q);
        RA_RXTHR:  reg_rdata <= REG_W'(rxthr_q);
        RA_TXLVL:  reg_rdata <= REG_W'(tx_lvl);
        RA_RXLVL:  reg_rdata <= REG_W'(rx_lvl);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign ctl_enabled  = en_q;
  assign tgt_addr     = tgt_q;
  assign ten_bit_mode = ten_q;

  assert_tx_over_full_R4: assert property (@(posedge clk) disable iff (rst)
    ev_tx_over |-> ($past(tx_lvl) == LW'(DEPTH)));
  assert_rx_over_full_R6: assert property (@(posedge clk) disable iff (rst)
    ev_rx_over |-> ($past(rx_lvl) == LW'(DEPTH)));
  assert_rx_under_empty_R5: assert property (@(posedge clk) disable iff (rst)
    ev_rx_under |-> ($past(rx_lvl) == '0));
  assert_disabled_flush_R8: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (tx_lvl == '0 && rx_lvl == '0));
  assert_abort_flush_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_abort |=> (tx_lvl == '0 && rx_lvl == '0));
  assert_target_locked_R9: assert property (@(posedge clk) disable iff (rst)
    en_q |=> ($stable(tgt_q) && $stable(ten_q)));
endmodule

// File: tb/tb_i2cm_cmd_front.sv
`timescale 1ns/1ps
module tb_i2cm_cmd_front;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic cmd_valid, cmd_ready = 0;
  logic [8:0] cmd_data;
  logic rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic xfer_abort = 0;
  logic ctl_enabled, ten_bit_mode;
  logic [9:0] tgt_addr;
  logic ev_tx_empty, ev_rx_full, ev_tx_over, ev_rx_over, ev_rx_under;
  int checks = 0, errors = 0;
  logic [8:0] tq[$];
  logic [7:0] rq[$];
  int txthr = 0, rxthr = 0;

  always #2 clk = ~clk;

  i2cm_cmd_front #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .xfer_abort(xfer_abort), .ctl_enabled(ctl_enabled),
    .tgt_addr(tgt_addr), .ten_bit_mode(ten_bit_mode), .ev_tx_empty(ev_tx_empty),
    .ev_rx_full(ev_rx_full), .ev_tx_over(ev_tx_over), .ev_rx_over(ev_rx_over),
    .ev_rx_under(ev_rx_under));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  function automatic int ev_exp(input int lvl, input int thr, input bit is_tx);
    return is_tx ? int'(lvl <= thr) : int'(lvl > thr);
  endfunction

  task automatic run_phase(input int n, input int rdy_pct, input int rxv_pct,
                           input int wr_pct, input int rd_pct);
    bit have_prev = 0, prev_rd = 0, prev_ab = 0, tx_both = 0, rx_both = 0;
    int exp_rd = 0, e_txo = 0, e_rxo = 0, e_rxu = 0, e_txe = 0, e_rxf = 0;
    for (int i = 0; i < n; i++) begin
      int x, t, r;
      bit wr, rd, rdy, rxv, ab;
      if (have_prev) begin
        check("R4 tx overflow pulse", ev_tx_over, e_txo);
        check("R6 rx overflow pulse", ev_rx_over, e_rxo);
        check("R5 rx underflow pulse", ev_rx_under, e_rxu);
        check("R3 tx empty event", ev_tx_empty, e_txe);
        check("R3 rx full event", ev_rx_full, e_rxf);
        if (prev_rd) check(rx_both ? "R11 rx push+pop read data" : "R10 read data",
                           reg_rdata, exp_rd);
      end
      check(prev_ab ? "R7 abort cmd_valid" : (tx_both ? "R11 cmd_valid" : "R1 cmd_valid"),
            cmd_valid, int'(tq.size() > 0));
      if (tq.size() > 0)
        check(tx_both ? "R11 cmd head" : "R1 cmd head", cmd_data, tq[0]);
      t = tq.size(); r = rq.size();
      x = $urandom % 100;
      wr = 0; rd = 0; reg_wr = 0; reg_rd = 0;
      prev_rd = 0;
      if (x < wr_pct) begin
        wr = 1; reg_wr = 1; reg_addr = 3'd0;
        reg_wdata = 16'($urandom % 512);
      end else if (x < wr_pct + rd_pct) begin
        rd = 1; reg_rd = 1; reg_addr = 3'd0; prev_rd = 1;
        exp_rd = (r > 0) ? int'(rq[0]) : 0;
      end else if (x < wr_pct + rd_pct + 10) begin
        reg_rd = 1; reg_addr = 3'd5; prev_rd = 1; exp_rd = t;
      end else if (x < wr_pct + rd_pct + 20) begin
        reg_rd = 1; reg_addr = 3'd6; prev_rd = 1; exp_rd = r;
      end
      rdy = ($urandom % 100) < rdy_pct;
      rxv = ($urandom % 100) < rxv_pct;
      ab  = ($urandom % 97) == 0;
      cmd_ready = rdy; rx_valid = rxv; rx_byte = 8'($urandom); xfer_abort = ab;
      e_txo = int'(wr && t == DEPTH);
      e_rxo = int'(rxv && r == DEPTH);
      e_rxu = int'(rd && r == 0);
      e_txe = ev_exp(t, txthr, 1);
      e_rxf = ev_exp(r, rxthr, 0);
      tx_both = wr && t < DEPTH && rdy && t > 0;
      rx_both = rxv && r < DEPTH && rd && r > 0;
      if (ab) begin
        tq.delete(); rq.delete();
      end else begin
        if (rdy && t > 0) void'(tq.pop_front());
        if (wr && t < DEPTH)
          tq.push_back(reg_wdata[8] ? 9'h100 : {1'b0, reg_wdata[7:0]});
        if (rd && r > 0) void'(rq.pop_front());
        if (rxv && r < DEPTH) rq.push_back(rx_byte);
      end
      prev_ab = ab;
      have_prev = 1;
      @(posedge clk); @(negedge clk);
    end
    reg_wr = 0; reg_rd = 0; cmd_ready = 0; rx_valid = 0; xfer_abort = 0;
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_1c2a));
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R8 reset cmd_valid", cmd_valid, 0);
    check("R10 reset rdata", reg_rdata, 0);
    @(negedge clk);
    check("R3 reset tx empty event", ev_tx_empty, 1);
    check("R3 reset rx full event", ev_rx_full, 0);
    // programming while disabled
    reg_write(3'd2, 16'h02A5);
    reg_write(3'd1, 16'h0002);
    reg_write(3'd0, 16'h0055);
    @(negedge clk);
    check("R8 disabled write ignored", cmd_valid, 0);
    reg_read(3'd5, d);
    check("R8 disabled tx level", d, 0);
    reg_write(3'd1, 16'h0003);
    reg_write(3'd2, 16'h0011);
    reg_write(3'd1, 16'h0001);
    check("R9 target locked", tgt_addr, 10'h2A5);
    check("R9 ten-bit locked", ten_bit_mode, 1);
    reg_read(3'd1, d);
    check("R9 control readback", d, 3);
    // write and read-request encodings
    reg_write(3'd0, 16'h00A3);
    reg_write(3'd0, 16'h01FF);
    check("R1 write command head", cmd_data, 9'h0A3);
    reg_read(3'd5, d);
    check("R2 tx level two", d, 2);
    cmd_ready = 1; @(posedge clk); @(negedge clk); cmd_ready = 0;
    check("R1 read request encoding", cmd_data, 9'h100);
    // disable flushes
    reg_write(3'd1, 16'h0000);
    @(negedge clk);
    reg_read(3'd5, d);
    check("R8 disable flush", d, 0);
    reg_write(3'd1, 16'h0001);
    // abort flushes both
    reg_write(3'd0, 16'h0011);
    rx_valid = 1; rx_byte = 8'h77; @(posedge clk); @(negedge clk); rx_valid = 0;
    reg_read(3'd6, d);
    check("R2 rx level one", d, 1);
    xfer_abort = 1; @(posedge clk); @(negedge clk); xfer_abort = 0;
    check("R7 abort tx flush", cmd_valid, 0);
    reg_read(3'd6, d);
    check("R7 abort rx flush", d, 0);
    // random phases
    txthr = DEPTH - 1; rxthr = 0;
    reg_write(3'd3, 16'(txthr)); reg_write(3'd4, 16'(rxthr));
    run_phase(4000, 20, 60, 50, 15);
    txthr = 2; rxthr = 5;
    reg_write(3'd3, 16'(txthr)); reg_write(3'd4, 16'(rxthr));
    run_phase(4000, 70, 25, 25, 45);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule